// File: doc/BRIEF.md
# Johnson Rotator

This block is a W-bit register that serves a low-transition test pattern source in two ways. In counting mode it is a twisted-ring counter. The complement of its last stage enters its first stage, so each new vector differs from the previous one in a single bit. In rotate mode the same register becomes a circular shifter. It passes its last stage back into its first stage unchanged, so the current vector can be streamed bit by bit out of the serial tap while the register keeps its contents.

An active-low serial clear input acts only in counting mode. While it is low, zeros enter the first stage, and every stage is empty after W clocks. No parallel clear path is needed for this. An enable input freezes the register in either mode. A synchronous active-high reset empties the whole register in one clock.

Top module: `johnson_rotator`

## Requirements
- R1: When `rst` is high at a rising clock edge, every bit of `vec` is 0 after that edge, whatever the other inputs are.
- R2: When `rst` is low and `step` is low, `vec` keeps its value across the edge, whatever `count_mode` and `sclr_n` are.
- R3: With `step`=1, `count_mode`=1 and `sclr_n`=1, the next `vec` is the old `vec` moved up one position (bit i takes old bit i-1), with bit 0 taking the inverse of old bit W-1.
- R4: With `step`=1, `count_mode`=1 and `sclr_n`=0, bit 0 takes 0 and the other bits move up one position, so any starting vector becomes all zeros after W such clocks.
- R5: With `step`=1 and `count_mode`=0, the next `vec` is the old `vec` moved up one position, with bit 0 taking old bit W-1 unchanged.
- R6: After W consecutive rotate steps, `vec` equals the vector it held before the first of them.
- R7: In counting mode with `sclr_n`=1, starting from a vector that has at most one change between adjacent bits, each step changes exactly one bit, and the new vector again has at most one change between adjacent bits.
- R8: Counting from all zeros visits 2W distinct vectors and then returns to all zeros on step 2W.
- R9: `tap` always equals bit W-1 of `vec`. During W rotate steps it presents the vector bits in the order W-1, W-2, ..., 0.
- R10: In rotate mode the level of `sclr_n` has no effect on the next vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; empties the register |
| step | input | 1 | Advance enable; the register holds when low |
| count_mode | input | 1 | 1 selects twisted-ring counting, 0 selects circular rotation |
| sclr_n | input | 1 | Active-low serial clear; feeds zeros while counting |
| vec | output | W | Parallel register contents, bit 0 is the first stage |
| tap | output | 1 | Serial output, the last stage (bit W-1) |

## Verification
Two functions can meet in one cycle. The first pair is the serial clear and the rotate path: the bench holds `sclr_n` low through rotate steps. Each resulting vector must equal a plain rotation, and the original vector must return after W steps. The second pair is reset and an active count step: the bench raises `rst` while `step` and counting are active. The cycle-by-cycle model expects all zeros on the next edge, so reset must win. A third case holds `step` low while the bench toggles `count_mode` and `sclr_n`, and no stage may move.

// File: rtl/johnson_rotator_pkg.sv
package johnson_rotator_pkg;

    localparam int MAX_W = 64;

    typedef enum logic [1:0] {
        FEED_HOLD   = 2'd0,
        FEED_ZERO   = 2'd1,
        FEED_INVERT = 2'd2,
        FEED_PASS   = 2'd3
    } feed_kind_e;

    typedef struct packed {
        logic advance;
        logic bit_in;
    } stage_cmd_t;

    // Number of positions where adjacent bits differ among the low n bits.
    function automatic int adj_flips(input logic [MAX_W-1:0] v, input int n);
        int cnt;
        cnt = 0;
        for (int i = 0; i < n - 1; i++) begin
            if (v[i] != v[i+1]) cnt++;
        end
        return cnt;
    endfunction

endpackage

// File: rtl/jr_ctrl.sv
module jr_ctrl
    import johnson_rotator_pkg::*;
(
    input  logic       step,
    input  logic       count_mode,
    input  logic       sclr_n,
    output feed_kind_e kind
);
    always_comb begin
        if (!step)            kind = FEED_HOLD;
        else if (!count_mode) kind = FEED_PASS;
        else if (!sclr_n)     kind = FEED_ZERO;
        else                  kind = FEED_INVERT;
    end
endmodule

// File: rtl/jr_feedback.sv
module jr_feedback
    import johnson_rotator_pkg::*;
(
    input  feed_kind_e kind,
    input  logic       last_bit,
    output stage_cmd_t cmd
);
    always_comb begin
        cmd.advance = (kind != FEED_HOLD);
        unique case (kind)
            FEED_INVERT: cmd.bit_in = ~last_bit;
            FEED_PASS:   cmd.bit_in = last_bit;
            default:     cmd.bit_in = 1'b0;
        endcase
    end
endmodule

// File: rtl/jr_stages.sv
module jr_stages
    import johnson_rotator_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  stage_cmd_t   cmd,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst)              q[i] <= 1'b0;
                else if (cmd.advance) q[i] <= cmd.bit_in;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst)              q[i] <= 1'b0;
                else if (cmd.advance) q[i] <= q[i-1];
            end
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk) rst |=> (q == '0))
        else $error("R1 violated: register not empty after reset");

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !cmd.advance |=> $stable(q))
        else $error("R2 violated: register moved without advance");
endmodule

// File: rtl/johnson_rotator.sv
module johnson_rotator
    import johnson_rotator_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         count_mode,
    input  logic         sclr_n,
    output logic [W-1:0] vec,
    output logic         tap
);
    localparam int LAST = W - 1;

    if (W < 2 || W > MAX_W) begin : g_bad_width
        initial $error("johnson_rotator: W must lie in 2..%0d", MAX_W);
    end

    feed_kind_e kind;
    stage_cmd_t cmd;
    logic [W-1:0] q;

    jr_ctrl u_ctrl (
        .step       (step),
        .count_mode (count_mode),
        .sclr_n     (sclr_n),
        .kind       (kind)
    );

    jr_feedback u_fb (
        .kind     (kind),
        .last_bit (q[LAST]),
        .cmd      (cmd)
    );

    jr_stages #(.W(W)) u_stages (
        .clk (clk),
        .rst (rst),
        .cmd (cmd),
        .q   (q)
    );

    assign vec = q;
    assign tap = q[LAST];

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (step && count_mode && sclr_n) |=> (vec == {$past(vec[W-2:0]), ~$past(vec[LAST])}))
        else $error("R3 violated: count step wrong");

    assert_serial_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (step && count_mode && !sclr_n) |=> (vec == {$past(vec[W-2:0]), 1'b0}))
        else $error("R4 violated: serial clear step wrong");

    // R5 and R10: rotation regardless of sclr_n
    assert_rotate_step_R5: assert property (@(posedge clk) disable iff (rst)
        (step && !count_mode) |=> (vec == {$past(vec[W-2:0]), $past(vec[LAST])}))
        else $error("R5/R10 violated: rotate step wrong");

    assert_single_change_R7: assert property (@(posedge clk) disable iff (rst)
        (step && count_mode && sclr_n &&
         adj_flips(MAX_W'(vec), W) <= 1)
        |=> (($countones(vec ^ $past(vec)) == 1) && (adj_flips(MAX_W'(vec), W) <= 1)))
        else $error("R7 violated: count step lost single-change property");
endmodule

// File: tb/tb_johnson_rotator.sv
`timescale 1ns/1ps
module tb_johnson_rotator;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst, step, count_mode, sclr_n;
    logic [W-1:0] vec;
    logic tap;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    bit model_q[$];

    always #2.5 clk = ~clk;

    johnson_rotator #(.W(W)) dut (
        .clk(clk), .rst(rst), .step(step), .count_mode(count_mode),
        .sclr_n(sclr_n), .vec(vec), .tap(tap)
    );

    function automatic logic [W-1:0] model_vec();
        logic [W-1:0] v;
        for (int i = 0; i < W; i++) v[i] = model_q[i];
        return v;
    endfunction

    function automatic int flips_of(logic [W-1:0] v);
        int n = 0;
        for (int i = 1; i < W; i++) if (v[i] != v[i-1]) n++;
        return n;
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // drive at negedge, model on the edge, compare at next negedge
    task automatic cyc(bit r, bit e, bit m, bit c, string tag);
        bit fb;
        rst = r; step = e; count_mode = m; sclr_n = c;
        @(posedge clk);
        if (r) begin
            foreach (model_q[i]) model_q[i] = 1'b0;
        end else if (e) begin
            if (m) fb = c ? !model_q[W-1] : 1'b0;
            else   fb = model_q[W-1];
            void'(model_q.pop_back());
            model_q.push_front(fb);
        end
        @(negedge clk);
        check(tag, vec, model_vec());
        check("R9 tap", W'(tap), W'(model_q[W-1]));
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] snap, prev, got;
        bit seen[logic [W-1:0]];
        for (int i = 0; i < W; i++) model_q.push_back(1'b0);
        rst = 1'b1; step = 1'b0; count_mode = 1'b1; sclr_n = 1'b1;
        @(negedge clk);
        cyc(1, 1, 1, 1, "R1 reset");
        cyc(1, 0, 0, 0, "R1 reset");

        // R8 / R3 / R7: full counting period from zero
        for (int k = 0; k < 2 * W; k++) begin
            prev = vec;
            seen[vec] = 1'b1;
            cyc(0, 1, 1, 1, "R3 count");
            check("R7 one bit changed", W'($countones(vec ^ prev)), W'(1));
            check("R7 adjacent flips<=1", W'(flips_of(vec) <= 1), W'(1));
        end
        check("R8 distinct states", W'(seen.num()), W'(2 * W));
        check("R8 back to zero", vec, '0);

        // R2: idle while other inputs toggle
        for (int k = 0; k < 3; k++) cyc(0, 1, 1, 1, "R3 count");
        snap = vec;
        cyc(0, 0, 0, 0, "R2 hold");
        cyc(0, 0, 1, 0, "R2 hold");
        cyc(0, 0, 0, 1, "R2 hold");
        cyc(0, 0, 1, 1, "R2 hold");
        check("R2 unchanged", vec, snap);

        // make an irregular pattern: rotate a bit, then count
        for (int k = 0; k < 2; k++) cyc(0, 1, 0, 1, "R5 rotate");
        for (int k = 0; k < 2; k++) cyc(0, 1, 1, 1, "R3 count");

        // R5, R10, R6: rotate with sclr_n alternating
        snap = vec;
        for (int k = 0; k < W; k++) cyc(0, 1, 0, k[0], "R10 rotate sclr ignored");
        check("R6 rotate returns", vec, snap);

        // R9: serial order out of tap
        snap = vec;
        got = '0;
        for (int k = 0; k < W; k++) begin
            got[W-1-k] = tap;
            cyc(0, 1, 0, 0, "R5 rotate");
        end
        check("R9 tap order", got, snap);

        // R4: serial clear from a non-zero vector
        for (int k = 0; k < 5; k++) cyc(0, 1, 1, 1, "R3 count");
        for (int k = 0; k < W; k++) cyc(0, 1, 1, 0, "R4 serial clear");
        check("R4 empty after W", vec, '0);

        // R1 against an active count step
        for (int k = 0; k < 4; k++) cyc(0, 1, 1, 1, "R3 count");
        cyc(1, 1, 1, 1, "R1 reset beats count");
        check("R1 zero", vec, '0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule